// File: doc/BRIEF.md
# Bit-Serial Column Sum Tree

This block adds up one unsigned field that is held across many storage rows. The field is streamed in bit-plane by bit-plane, least significant plane first: each accepted beat carries one bit from every row. A pipelined binary tree of adders counts the ones in that plane. A shift-and-add accumulator weights each count by the plane's bit position and builds the scalar total. The result is `M_BITS + log2(N_ROWS)` bits wide, so it cannot overflow.

The input is a valid/ready stream. A beat is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_first` marks the first plane of a field and `in_last` marks the final plane. The result leaves on a valid/ready stream with a small rolling sequence number. A new field may follow the previous one on the very next beat. Every field in flight keeps its own plane index and sequence number, so results come out separately and in order.

Back-pressure is whole-block. While a result is offered and not taken, `in_ready` is low and every pipeline stage holds. When `out_ready` is high, `in_ready` is high as well.

Top module: `rbt_reduce_tree`

## Requirements
- R1: A field of n planes (plane b carrying bit b of every row's value) yields `out_sum` equal to the sum over all rows of each row's value restricted to its low n bits.
- R2: With `out_ready` held high, `out_valid` is high in the cycle that follows the (log2(N_ROWS)+1)-th rising edge after the edge that accepted the field's final plane.
- R3: A new field may start on the beat right after the previous field's final plane. Each field produces exactly one result, and results appear in the order the fields were closed.
- R4: A field closes at a plane flagged `in_last` or at its M_BITS-th plane, whichever comes first. A beat accepted after a closed field starts a new field even when `in_first` is low.
- R5: A field closed by `in_last` after fewer than M_BITS planes treats the missing upper bits of every row as zero.
- R6: `in_first` on a beat while a field is open abandons that field. The abandoned field produces no result and does not advance `out_tag`.
- R7: `out_tag` is 0 on the first result after reset and grows by one (modulo 2^TAG_W) with each further result.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_sum` and `out_tag` stay unchanged. A beat offered while `in_ready` is low is not taken and is not counted.
- R9: After reset, `out_valid` is low and `in_ready` is high.
- R10: Cycles with `in_valid` low may fall between the planes of one field without changing its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Plane beat offered |
| in_ready | output | 1 | Block can take a plane this cycle |
| in_slice | input | N_ROWS | One bit from every row; bit r belongs to row r |
| in_first | input | 1 | Beat is the first plane of a new field |
| in_last | input | 1 | Beat is the final plane of the field |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | M_BITS+log2(N_ROWS) | Column total |
| out_tag | output | TAG_W | Rolling sequence number of the result |

## Verification
The hardest state to reach is a result held under back-pressure while the tree still holds planes of one or two later fields. Those planes must freeze in place and must neither be lost nor counted twice. The random phase creates this state by dropping `out_ready` at random while fields of random length stream back to back with random gaps. A reference model computes each expected total and sequence number, and every result is compared against it. Directed runs cover the remaining corners: a single-plane field, a full all-ones field, a field closed only by its plane count and followed by one with no start marker, and a field abandoned by a start marker arriving mid-field.

// File: rtl/rbt_pkg.sv
package rbt_pkg;

  // Width of a plane index able to count 0 .. m-1 (at least one bit).
  function automatic int unsigned idx_width(input int unsigned m);
    return (m > 1) ? $clog2(m) : 1;
  endfunction

  // Number of partial counts held after tree level k.
  function automatic int unsigned level_count(input int unsigned n, input int unsigned k);
    return n >> k;
  endfunction

  // Width of each partial count after tree level k.
  function automatic int unsigned level_width(input int unsigned k);
    return k + 1;
  endfunction

endpackage

// File: rtl/rbt_level.sv
module rbt_level #(
  parameter int unsigned IN_CNT = 2,
  parameter int unsigned IN_W   = 1,
  parameter type         SIDE_T = logic
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              en,
  input  logic [IN_CNT*IN_W-1:0]            in_data,
  input  SIDE_T                             in_side,
  output logic [(IN_CNT/2)*(IN_W+1)-1:0]    out_data,
  output SIDE_T                             out_side
);
  localparam int unsigned OUT_CNT = IN_CNT / 2;
  localparam int unsigned OUT_W   = IN_W + 1;

  // Pairwise adders of neighbouring rows, one bit wider than their inputs.
  for (genvar j = 0; j < OUT_CNT; j++) begin : g_pair
    logic [OUT_W-1:0] pair_sum;
    assign pair_sum = OUT_W'(in_data[(2*j)*IN_W +: IN_W])
                    + OUT_W'(in_data[(2*j+1)*IN_W +: IN_W]);
    always_ff @(posedge clk) begin
      if (en) out_data[j*OUT_W +: OUT_W] <= pair_sum;
    end
  end

  // Sideband travels in lock-step with the counts.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  out_side <= '0;
    else if (en) out_side <= in_side;
  end
endmodule

// File: rtl/rbt_framer.sv
module rbt_framer #(
  parameter int unsigned M_BITS = 8,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned TAG_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic             in_last,
  output logic             take,
  output logic             start,
  output logic             close,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  logic             open_q;
  logic [IDX_W-1:0] idx_q;
  logic [TAG_W-1:0] tag_q;

  assign take  = in_valid && en;
  assign start = in_first || !open_q;
  assign idx   = start ? '0 : idx_q;
  assign close = in_last || (idx == IDX_W'(M_BITS - 1));
  assign tag   = tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      idx_q  <= '0;
      tag_q  <= '0;
    end else if (take) begin
      open_q <= !close;
      idx_q  <= idx + IDX_W'(1);
      if (close) tag_q <= tag_q + TAG_W'(1);
    end
  end
endmodule

// File: rtl/rbt_accum.sv
module rbt_accum #(
  parameter int unsigned ROOT_W = 5,
  parameter int unsigned SUM_W  = 12,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned TAG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              r_vld,
  input  logic              r_first,
  input  logic              r_last,
  input  logic [IDX_W-1:0]  r_idx,
  input  logic [TAG_W-1:0]  r_tag,
  input  logic [ROOT_W-1:0] r_cnt,
  output logic              out_valid,
  output logic [SUM_W-1:0]  out_sum,
  output logic [TAG_W-1:0]  out_tag
);
  logic [SUM_W-1:0] acc_q;
  logic [SUM_W-1:0] weighted;
  logic [SUM_W-1:0] acc_n;

  assign weighted = SUM_W'(r_cnt) << r_idx;
  assign acc_n    = r_first ? weighted : (acc_q + weighted);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_tag   <= '0;
    end else if (en) begin
      out_valid <= r_vld && r_last;
      if (r_vld) begin
        acc_q <= acc_n;
        if (r_last) begin
          out_sum <= acc_n;
          out_tag <= r_tag;
        end
      end
    end
  end
endmodule

// File: rtl/rbt_reduce_tree.sv
module rbt_reduce_tree #(
  parameter int unsigned N_ROWS = 16,
  parameter int unsigned M_BITS = 8,
  parameter int unsigned TAG_W  = 2,
  localparam int unsigned LOG_N = $clog2(N_ROWS),
  localparam int unsigned SUM_W = M_BITS + LOG_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [N_ROWS-1:0] in_slice,
  input  logic              in_first,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SUM_W-1:0]  out_sum,
  output logic [TAG_W-1:0]  out_tag
);
  import rbt_pkg::*;

  localparam int unsigned IDX_W  = idx_width(M_BITS);
  localparam int unsigned ROOT_W = level_width(LOG_N);

  typedef struct packed {
    logic             vld;
    logic             first;
    logic             last;
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
  } side_t;

  logic             en;
  logic             f_take, f_start, f_close;
  logic [IDX_W-1:0] f_idx;
  logic [TAG_W-1:0] f_tag;

  // Whole-pipeline stall while a result waits for its consumer.
  assign en       = !(out_valid && !out_ready);
  assign in_ready = en;

  rbt_framer #(.M_BITS(M_BITS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .en(en),
    .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
    .take(f_take), .start(f_start), .close(f_close), .idx(f_idx), .tag(f_tag)
  );

  // Level 0 registers the plane; levels 1..LOG_N halve the count each.
  for (genvar k = 0; k <= LOG_N; k++) begin : g_lvl
    localparam int unsigned CNT = level_count(N_ROWS, k);
    localparam int unsigned W   = level_width(k);
    logic [CNT*W-1:0] data;
    side_t            side;

    if (k == 0) begin : g_src
      always_ff @(posedge clk) begin
        if (en) data <= in_slice;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) side <= '0;
        else if (en) begin
          side.vld   <= f_take;
          side.first <= f_start;
          side.last  <= f_close;
          side.idx   <= f_idx;
          side.tag   <= f_tag;
        end
      end
    end else begin : g_add
      rbt_level #(
        .IN_CNT(level_count(N_ROWS, k - 1)),
        .IN_W  (level_width(k - 1)),
        .SIDE_T(side_t)
      ) u_level (
        .clk(clk), .rst_n(rst_n), .en(en),
        .in_data(g_lvl[k-1].data), .in_side(g_lvl[k-1].side),
        .out_data(data), .out_side(side)
      );
    end
  end

  rbt_accum #(.ROOT_W(ROOT_W), .SUM_W(SUM_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .en(en),
    .r_vld(g_lvl[LOG_N].side.vld), .r_first(g_lvl[LOG_N].side.first),
    .r_last(g_lvl[LOG_N].side.last), .r_idx(g_lvl[LOG_N].side.idx),
    .r_tag(g_lvl[LOG_N].side.tag), .r_cnt(g_lvl[LOG_N].data),
    .out_valid(out_valid), .out_sum(out_sum), .out_tag(out_tag)
  );
endmodule

// File: rtl/rbt_reduce_tree_chk.sv
module rbt_reduce_tree_chk #(
  parameter int unsigned N_ROWS = 16,
  parameter int unsigned M_BITS = 8,
  parameter int unsigned TAG_W  = 2,
  parameter int unsigned SUM_W  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [SUM_W-1:0] out_sum,
  input logic [TAG_W-1:0] out_tag
);
  localparam logic [SUM_W-1:0] MAX_SUM = SUM_W'(N_ROWS * ((2 ** M_BITS) - 1));

  logic             held_q;
  logic             have_prev;
  logic [TAG_W-1:0] prev_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q    <= 1'b0;
      have_prev <= 1'b0;
      prev_tag  <= '0;
    end else begin
      held_q <= out_valid && !out_ready;
      if (out_valid && out_ready) begin
        have_prev <= 1'b1;
        prev_tag  <= out_tag;
      end
    end
  end

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sum) && $stable(out_tag));

  p_stall_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_sum_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sum <= MAX_SUM);

  p_tag_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !held_q && have_prev |-> out_tag == TAG_W'(prev_tag + TAG_W'(1)));

  p_tag_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !have_prev |-> out_tag == '0);
endmodule

bind rbt_reduce_tree rbt_reduce_tree_chk #(
  .N_ROWS(N_ROWS), .M_BITS(M_BITS), .TAG_W(TAG_W), .SUM_W(SUM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_sum(out_sum), .out_tag(out_tag)
);

// File: tb/rbt_reduce_tree_tb.sv
module rbt_reduce_tree_tb;
  localparam int N  = 16;
  localparam int M  = 8;
  localparam int LG = 4;
  localparam int SW = M + LG;
  localparam int TW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [N-1:0]  in_slice = '0;
  logic          in_first = 1'b0;
  logic          in_last = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [SW-1:0] out_sum;
  logic [TW-1:0] out_tag;

  rbt_reduce_tree #(.N_ROWS(N), .M_BITS(M), .TAG_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_slice(in_slice), .in_first(in_first), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum), .out_tag(out_tag)
  );

  always #2 clk = ~clk;

  int            nvec = 0;
  int            nerr = 0;
  int            cyc = 0;
  bit            running = 0;
  bit            done = 0;
  bit            rand_ready = 0;
  bit            lat_on = 0;
  bit            gap_on = 0;
  int            last_acc_cyc = 0;
  logic [M-1:0]  vals [N];
  logic [SW-1:0] exp_q [$];
  int            lat_q [$];
  logic [TW-1:0] exp_tag = '0;
  bit            hold_prev = 0;
  logic [SW-1:0] hold_sum = '0;
  logic [TW-1:0] hold_tag = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] ref_sum(input int nsl);
    logic [SW-1:0] s = '0;
    for (int r = 0; r < N; r++)
      for (int b = 0; b < nsl; b++)
        if (vals[r][b]) s = s + (SW'(1) << b);
    return s;
  endfunction

  function automatic logic [N-1:0] plane(input int b);
    logic [N-1:0] p;
    for (int r = 0; r < N; r++) p[r] = vals[r][b];
    return p;
  endfunction

  task automatic fill(input int mode);
    for (int r = 0; r < N; r++)
      case (mode)
        0: vals[r] = '0;
        1: vals[r] = '1;
        default: vals[r] = M'($urandom);
      endcase
  endtask

  // Offer one plane at a negedge and hold it until an edge accepts it.
  task automatic send_slice(input logic [N-1:0] p, input bit f, input bit l);
    bit ok;
    @(negedge clk);
    in_valid = 1'b1; in_slice = p; in_first = f; in_last = l;
    forever begin
      ok = 0;
      #1;
      if (in_ready) ok = 1;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    #1;
    last_acc_cyc = cyc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_slice = N'($urandom); in_first = 1'b0; in_last = 1'b0;
    end
  endtask

  task automatic send_set(input int nsl, input bit use_last, input bit fmark, input bit push);
    for (int b = 0; b < nsl; b++) begin
      send_slice(plane(b), fmark && (b == 0), use_last && (b == nsl - 1));
      if (gap_on && ($urandom % 4 == 0)) idle(1 + $urandom % 3);
    end
    if (push) begin
      exp_q.push_back(ref_sum(nsl));
      lat_q.push_back(last_acc_cyc);
    end
  endtask

  // Monitor and consumer: drive out_ready at negedge, sample 1 ns later.
  always @(negedge clk) begin
    out_ready = rand_ready ? ($urandom % 3 != 0) : 1'b1;
    #1;
    if (running) begin
      if (hold_prev) begin
        check(out_valid && out_sum == hold_sum && out_tag == hold_tag,
              "R8 held result changed", int'(out_sum), int'(hold_sum));
      end
      if (out_valid && !out_ready)
        check(!in_ready, "R8 in_ready during stall", int'(in_ready), 0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected result", int'(out_sum), -1);
        end else begin
          logic [SW-1:0] e;
          int            t;
          e = exp_q.pop_front();
          t = lat_q.pop_front();
          check(out_sum == e, "R1 column sum", int'(out_sum), int'(e));
          check(out_tag == exp_tag, "R7 tag sequence", int'(out_tag), int'(exp_tag));
          if (lat_on) check(cyc == t + LG + 1, "R2 latency", cyc - t, LG + 1);
          exp_tag = exp_tag + TW'(1);
        end
      end
      hold_prev = out_valid && !out_ready;
      hold_sum  = out_sum;
      hold_tag  = out_tag;
    end
  end

  task automatic drain();
    idle(1);
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    idle(LG + 4);
    check(exp_q.size() == 0, "R3 all results delivered", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL R3 watchdog actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0bad));
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R9 in_ready after reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R9 idle after release", int'(out_valid), 0);
    running = 1;
    lat_on = 1;

    // R1/R2: full field of all ones, then all zeros.
    fill(1); send_set(M, 1, 1, 1); drain();
    fill(0); send_set(M, 1, 1, 1); drain();
    // R5: single plane and three planes closed early.
    fill(2); send_set(1, 1, 1, 1); drain();
    fill(2); send_set(3, 1, 1, 1); drain();
    // R3: three fields back to back with no idle beat.
    fill(2); send_set(M, 1, 1, 1);
    fill(2); send_set(M, 1, 1, 1);
    fill(1); send_set(2, 1, 1, 1);
    drain();
    // R4: field closed by plane count only, next field with no start marker.
    fill(2); send_set(M, 0, 1, 1);
    fill(2); send_set(5, 1, 0, 1);
    drain();
    // R6: abandoned field, then a fresh field started by in_first.
    fill(1); send_set(3, 0, 1, 0);
    fill(2); send_set(M, 1, 1, 1);
    drain();
    // R10: idle gaps inside fields, latency still checked on last plane.
    gap_on = 1;
    for (int i = 0; i < 6; i++) begin fill(2); send_set(1 + $urandom % M, 1, 1, 1); end
    drain();

    // Random phase with back-pressure (R8), gaps (R10) and mixed closes.
    lat_on = 0;
    rand_ready = 1;
    for (int i = 0; i < 250; i++) begin
      int sel;
      sel = $urandom % 10;
      fill(2);
      if (sel == 0) begin
        send_set(1 + $urandom % (M - 1), 0, 1, 0);
        fill(2);
        send_set(1 + $urandom % M, 1, 1, 1);
      end else if (sel == 1) begin
        send_set(M, 0, 1, 1);
      end else begin
        send_set(1 + $urandom % M, 1, ($urandom % 2) == 0, 1);
      end
    end
    rand_ready = 0;
    drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule